// File: doc/BRIEF.md
# Four-Word Pair Merger

This block takes four words that arrive as two ascending pairs and produces one ascending vector of four words. It is a small sorting-network fragment meant to sit inside a wider merge tree. A first layer of compare-and-exchange cells works on mirrored positions of the input. Its result is held in one pipeline register. A second layer then orders adjacent positions of that register.

Word width is a parameter. Word `i` occupies bits `[i*W +: W]` of each packed vector, and word 0 is the smallest position. A valid strobe travels alongside the data and comes out one clock later. There is no backpressure. Descending operation and general sorting of four arbitrary words are not supported.

Top module: `pair_merge4`

## Requirements
- R1: While reset is low, and on the first cycle after it, `out_valid` is 0 and `out_words` is all zeros.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise.
- R3: With input words x0..x3 (word i at bits [i*W +: W]), the first layer forms lo_a=min(x0,x3), hi_a=max(x0,x3), lo_b=min(x1,x2) and hi_b=max(x1,x2). The words are then held in the order lo_a, lo_b, hi_b, hi_a. One cycle after capture, the output words 0..3 are min(lo_a,lo_b), max(lo_a,lo_b), min(hi_b,hi_a) and max(hi_b,hi_a). This holds for any inputs, sorted or not.
- R4: For any captured input, output word 0 equals the smallest of the four input words and output word 3 equals the largest.
- R5: When x0<=x1 and x2<=x3, the output satisfies word0<=word1<=word2<=word3 and is a permutation of the inputs. Equal values and the extreme values 0 and all-ones are included.
- R6: A cycle with `in_valid` low leaves `out_words` unchanged in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input words are valid this cycle |
| in_words | input | 4*W | Four input words, word i at [i*W +: W] |
| out_valid | output | 1 | Merged words are valid |
| out_words | output | 4*W | Merged words, word i at [i*W +: W] |

## Verification
The full-order assertion for R5 only claims anything when the captured input was two ascending pairs. The stimulus for the R5 tests keeps to that shape, using random words that are sorted within each pair before they are driven. Unsorted inputs are driven only in the R3 tests, where the expected value comes from the stage formula rather than a full sort. The minimum, maximum and pair-order properties hold for every input, so those tests place no limits on the stimulus.

// File: rtl/pair_merge4.sv
module pair_merge4 #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [4*W-1:0] in_words,
  output logic           out_valid,
  output logic [4*W-1:0] out_words
);

  logic [W-1:0] x0, x1, x2, x3;
  logic [W-1:0] lo_a, hi_a, lo_b, hi_b;
  logic [W-1:0] r0, r1, r2, r3;
  logic [W-1:0] y0, y1, y2, y3;
  logic         swap_a, swap_b, swap_lo, swap_hi;
  logic         vld_q;

  assign x0 = in_words[0*W +: W];
  assign x1 = in_words[1*W +: W];
  assign x2 = in_words[2*W +: W];
  assign x3 = in_words[3*W +: W];

  assign swap_a = x0 > x3;
  assign swap_b = x1 > x2;
  assign lo_a   = swap_a ? x3 : x0;
  assign hi_a   = swap_a ? x0 : x3;
  assign lo_b   = swap_b ? x2 : x1;
  assign hi_b   = swap_b ? x1 : x2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0    <= '0;
      r1    <= '0;
      r2    <= '0;
      r3    <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        r0 <= lo_a;
        r1 <= lo_b;
        r2 <= hi_b;
        r3 <= hi_a;
      end
    end
  end

  assign swap_lo = r0 > r1;
  assign swap_hi = r2 > r3;
  assign y0 = swap_lo ? r1 : r0;
  assign y1 = swap_lo ? r0 : r1;
  assign y2 = swap_hi ? r3 : r2;
  assign y3 = swap_hi ? r2 : r3;

  assign out_valid = vld_q;
  assign out_words = {y3, y2, y1, y0};

  function automatic logic [W-1:0] min4(logic [4*W-1:0] v);
    logic [W-1:0] m;
    m = v[0 +: W];
    for (int i = 1; i < 4; i++) if (v[i*W +: W] < m) m = v[i*W +: W];
    return m;
  endfunction

  function automatic logic [W-1:0] max4(logic [4*W-1:0] v);
    logic [W-1:0] m;
    m = v[0 +: W];
    for (int i = 1; i < 4; i++) if (v[i*W +: W] > m) m = v[i*W +: W];
    return m;
  endfunction

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_words == '0));

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_pair_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (y0 <= y1 && y2 <= y3));

  assert_min_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_words[0 +: W] == min4($past(in_words))));

  assert_max_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_words[3*W +: W] == max4($past(in_words))));

  assert_full_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && x0 <= x1 && x2 <= x3) |=> (y1 <= y2));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_words));

endmodule

// File: tb/pair_merge4_tb.sv
module pair_merge4_tb_top;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [4*W-1:0] in_words = '0;
  logic           out_valid;
  logic [4*W-1:0] out_words;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  pair_merge4 #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_words(in_words),
    .out_valid(out_valid), .out_words(out_words)
  );

  function automatic logic [W-1:0] mn(logic [W-1:0] a, logic [W-1:0] b);
    return (a < b) ? a : b;
  endfunction
  function automatic logic [W-1:0] mx(logic [W-1:0] a, logic [W-1:0] b);
    return (a < b) ? b : a;
  endfunction

  function automatic logic [4*W-1:0] pack(logic [W-1:0] a, logic [W-1:0] b,
                                          logic [W-1:0] c, logic [W-1:0] d);
    return {d, c, b, a};
  endfunction

  function automatic logic [4*W-1:0] model(logic [4*W-1:0] v);
    logic [W-1:0] la, ha, lb, hb;
    la = mn(v[0 +: W], v[3*W +: W]);
    ha = mx(v[0 +: W], v[3*W +: W]);
    lb = mn(v[W +: W], v[2*W +: W]);
    hb = mx(v[W +: W], v[2*W +: W]);
    return pack(mn(la, lb), mx(la, lb), mn(hb, ha), mx(hb, ha));
  endfunction

  function automatic logic [4*W-1:0] full_sort(logic [4*W-1:0] v);
    logic [W-1:0] w [4];
    logic [W-1:0] t;
    for (int i = 0; i < 4; i++) w[i] = v[i*W +: W];
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3 - i; j++)
        if (w[j] > w[j+1]) begin t = w[j]; w[j] = w[j+1]; w[j+1] = t; end
    return pack(w[0], w[1], w[2], w[3]);
  endfunction

  task automatic check(string req, logic [4*W-1:0] act, logic [4*W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic push(logic [4*W-1:0] v);
    @(negedge clk);
    in_valid = 1'b1;
    in_words = v;
    @(negedge clk);
    in_valid = 1'b0;
    in_words = '0;
  endtask

  task automatic t_reset;
    in_valid = 1'b1;
    in_words = pack(16'h1111, 16'h2222, 16'h3333, 16'h4444);
    repeat (3) @(negedge clk);
    check_bit("R1 valid in reset", out_valid, 1'b0);
    check("R1 words in reset", out_words, '0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R1 valid after reset", out_valid, 1'b0);
    check("R1 words after reset", out_words, '0);
  endtask

  task automatic t_basic;
    logic [4*W-1:0] v;
    v = pack(16'd3, 16'd9, 16'd1, 16'd7);
    push(v);
    check_bit("R2 valid one cycle later", out_valid, 1'b1);
    check("R5 basic merge", out_words, pack(16'd1, 16'd3, 16'd7, 16'd9));
    @(negedge clk);
    check_bit("R2 valid drops", out_valid, 1'b0);
  endtask

  task automatic t_unsorted_r3;
    logic [4*W-1:0] v;
    v = pack(16'd50, 16'd10, 16'd40, 16'd20);
    push(v);
    check("R3 stage formula unsorted", out_words, model(v));
    check("R4 min word", {48'd0, out_words[0 +: W]}, {48'd0, 16'd10});
    v = pack(16'd8, 16'd2, 16'd6, 16'd4);
    push(v);
    check("R3 stage formula second", out_words, model(v));
  endtask

  task automatic t_equal_edges;
    push(pack(16'd5, 16'd5, 16'd5, 16'd5));
    check("R5 all equal", out_words, pack(16'd5, 16'd5, 16'd5, 16'd5));
    push(pack(16'd0, 16'hFFFF, 16'd0, 16'hFFFF));
    check("R5 extremes", out_words, pack(16'd0, 16'd0, 16'hFFFF, 16'hFFFF));
    push(pack(16'd4, 16'd6, 16'd4, 16'd6));
    check("R5 duplicate pairs", out_words, pack(16'd4, 16'd4, 16'd6, 16'd6));
  endtask

  task automatic t_hold;
    logic [4*W-1:0] v;
    v = pack(16'd2, 16'd12, 16'd7, 16'd8);
    push(v);
    @(negedge clk);
    in_words = pack(16'hAAAA, 16'h0001, 16'h5555, 16'h0002);
    @(negedge clk);
    check("R6 hold with invalid input", out_words, full_sort(v));
    in_words = '0;
  endtask

  task automatic t_stream;
    logic [4*W-1:0] v, prev;
    logic [W-1:0] a, b, c, d;
    bit have = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (have) begin
        check_bit("R2 stream valid", out_valid, 1'b1);
        check("R5 stream merge", out_words, full_sort(prev));
      end
      a = W'($urandom); b = W'($urandom); c = W'($urandom); d = W'($urandom);
      v = pack(mn(a, b), mx(a, b), mn(c, d), mx(c, d));
      in_valid = 1'b1;
      in_words = v;
      prev = v;
      have = 1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R5 stream last", out_words, full_sort(prev));
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_basic();
        t_unsorted_r3();
        t_equal_edges();
        t_hold();
        t_stream();
      end
      begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule